// File: doc/BRIEF.md
# Speculative Block Commit Cache

This block sits beside one processor that runs a code block speculatively. The compiler picks the block. Stores made inside the block go to a small private write buffer and are not seen by anyone else. Loads are served from that buffer when they hit it. A load that misses goes to memory, and its address is kept in a read-tracking set, in a "depends" state.

Other blocks drain their buffers onto a shared write bus when they commit. This block snoops that bus. If a write from another block lands on an address this block has already read, the block read too early. The block raises a violation and must be aborted, which throws away everything it buffered.

Commits happen in program order. When this block is told it holds the commit turn, it sweeps its buffer onto the bus one word at a time. Each write is tagged with the block's own ID, so its own snoop logic ignores it.

Top module: `spec_commit_cache`

## Requirements
- R1: After reset both stores are empty. `proc_req_ready` is high. `proc_rsp_valid`, `mem_rd_req`, `bus_wr_valid`, `violation`, `overflow`, `commit_done` and `abort_done` are low.
- R2: An accepted store (`proc_req_we`=1) is held in the write buffer and produces no bus write until a commit drains it.
- R3: A load whose address is in the write buffer returns the most recent buffered data with `proc_rsp_valid` one cycle after acceptance, and raises no memory read.
- R4: A load that misses the write buffer drives `mem_rd_req` with its address from the cycle after acceptance until `mem_rd_ack`. It returns `mem_rd_data` with `proc_rsp_valid` one cycle after the acknowledge, and records the address in the read-tracking set.
- R5: A snooped write whose ID differs from `SELF_ID`, to a tracked address, sets `violation` on the next cycle. This includes an address being filled in the same cycle. `violation` then stays high until an abort.
- R6: A snooped write carrying `SELF_ID`, or one to an untracked address, leaves `violation` unchanged.
- R7: Draining starts only when `commit_req` and `commit_grant` are both high and `violation` is low. The drain issues buffered words lowest entry first, where entries fill lowest free slot first, so the bus sees words in order of their first store. It issues one word per cycle with `bus_ready`, keeps the same word while `bus_ready` is low, and tags every write with `SELF_ID`.
- R8: One cycle after the last word is accepted, a drain that finds the buffer empty ends, and `commit_done` pulses for one cycle the cycle after that. Both stores are then empty, so a load of a previously stored address goes to memory.
- R9: `abort_req` empties both stores in one cycle and clears `violation`, even if a snoop hit arrives in the same cycle. `abort_done` pulses one cycle later. Buffered data never reaches the bus afterwards.
- R10: A store to a new address while the write buffer is full raises `overflow`, holds `proc_req_ready` low, and allocates nothing until a commit frees the buffer.
- R11: A store to an address already buffered overwrites that entry in place. This works even when the buffer is full, and the commit then writes the address only once.
- R12: A load that misses both stores while the read-tracking set is full raises `overflow` and stalls. A load to an already tracked address still proceeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| proc_req_valid | input | 1 | Processor request present |
| proc_req_we | input | 1 | 1 = store, 0 = load |
| proc_req_addr | input | ADDR_W | Word address |
| proc_req_wdata | input | DATA_W | Store data |
| proc_req_ready | output | 1 | Request accepted this cycle |
| proc_rsp_valid | output | 1 | Load data valid |
| proc_rsp_rdata | output | DATA_W | Load data |
| overflow | output | 1 | Request stalled on a full store |
| mem_rd_req | output | 1 | Memory read outstanding |
| mem_rd_addr | output | ADDR_W | Memory read address |
| mem_rd_ack | input | 1 | Memory read data returned |
| mem_rd_data | input | DATA_W | Memory read data |
| bus_wr_valid | output | 1 | Commit write on shared bus |
| bus_wr_addr | output | ADDR_W | Commit write address |
| bus_wr_data | output | DATA_W | Commit write data |
| bus_wr_id | output | ID_W | Tag of the writing block |
| bus_ready | input | 1 | Bus takes the write this cycle |
| snoop_valid | input | 1 | A write is seen on the shared bus |
| snoop_addr | input | ADDR_W | Snooped write address |
| snoop_id | input | ID_W | Snooped writer tag |
| commit_req | input | 1 | Block finished, asks to commit |
| commit_grant | input | 1 | Block holds the commit turn |
| commit_done | output | 1 | One-cycle pulse: drain complete |
| abort_req | input | 1 | Discard speculative state |
| abort_done | output | 1 | One-cycle pulse: abort complete |
| violation | output | 1 | Dependency violation detected |

## Verification
Two collisions matter most. The first is a memory fill landing in the same cycle as a foreign snoop to the same address. The bench raises `mem_rd_ack` and drives the snoop on the same edge, and expects `violation` on the next cycle even though the address was not yet tracked. The second is an abort arriving together with a snoop hit. The bench sets both at once and expects `violation` to stay low with `abort_done` pulsing. A behavioural model tracks the expected violation flag and compares it with the port on every clock.

// File: rtl/scc_pkg.sv
// Shared types for the speculative commit cache.
package scc_pkg;
    // Control states of the block: idle, waiting for memory fill, draining.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_DRAIN = 2'd2
    } scc_state_e;
endpackage

// File: rtl/scc_write_buffer.sv
// Private write buffer: fully associative, word-addressed.
// Stores allocate the lowest free entry, or overwrite a matching one.
// The drain side always presents the lowest valid entry as head.
// Assumes store_en and pop_en are never high together.
module scc_write_buffer #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_all,
    input  logic [ADDR_W-1:0] probe_addr,
    input  logic              store_en,
    input  logic [DATA_W-1:0] store_data,
    output logic              hit,
    output logic [DATA_W-1:0] hit_data,
    output logic              full,
    input  logic              pop_en,
    output logic              any_valid,
    output logic [ADDR_W-1:0] head_addr,
    output logic [DATA_W-1:0] head_data
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0]  valid_q;
    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic [DATA_W-1:0] data_q [DEPTH];
    logic [DEPTH-1:0]  match;
    logic [IDX_W-1:0]  hit_idx, free_idx, head_idx;

    // One comparator per entry against the processor address.
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match[g] = valid_q[g] && (addr_q[g] == probe_addr);
    end

    // Lowest-index pick of the hit, free and head entries.
    always_comb begin
        hit_idx  = '0;
        free_idx = '0;
        head_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (match[i])    hit_idx  = IDX_W'(i);
            if (!valid_q[i]) free_idx = IDX_W'(i);
            if (valid_q[i])  head_idx = IDX_W'(i);
        end
    end

    assign hit       = |match;
    assign full      = &valid_q;
    assign any_valid = |valid_q;
    assign hit_data  = data_q[hit_idx];
    assign head_addr = addr_q[head_idx];
    assign head_data = data_q[head_idx];

    // Valid bits: allocate on new store, drop on drain pop, clear in bulk.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_all) begin
            valid_q <= '0;
        end else begin
            if (store_en && !hit && !full) valid_q[free_idx] <= 1'b1;
            if (pop_en)                    valid_q[head_idx] <= 1'b0;
        end
    end

    // Address and data payload: overwrite on hit, fill on allocation.
    always_ff @(posedge clk) begin
        if (store_en) begin
            if (hit) begin
                data_q[hit_idx] <= store_data;
            end else if (!full) begin
                addr_q[free_idx] <= probe_addr;
                data_q[free_idx] <= store_data;
            end
        end
    end

    // R7: the drain never pops an empty buffer.
    assert_pop_needs_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pop_en |-> any_valid);
endmodule

// File: rtl/scc_read_tracker.sv
// Read-tracking set: remembers addresses loaded from memory (depends state)
// and flags a snoop that hits one of them, or the address being filled
// in the same cycle.
// Assumes the caller only inserts when the set has room or already holds the address.
module scc_read_tracker #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_all,
    input  logic [ADDR_W-1:0] probe_addr,
    output logic              probe_hit,
    output logic              full,
    input  logic              ins_en,
    input  logic [ADDR_W-1:0] ins_addr,
    input  logic              snoop_en,
    input  logic [ADDR_W-1:0] snoop_addr,
    output logic              snoop_hit
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0]  valid_q;
    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic [DEPTH-1:0]  m_probe, m_ins, m_snp;
    logic [IDX_W-1:0]  free_idx;
    logic              do_alloc;

    // Three comparators per entry: processor probe, fill address, snoop address.
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign m_probe[g] = valid_q[g] && (addr_q[g] == probe_addr);
        assign m_ins[g]   = valid_q[g] && (addr_q[g] == ins_addr);
        assign m_snp[g]   = valid_q[g] && (addr_q[g] == snoop_addr);
    end

    // Lowest free entry for a new tracked address.
    always_comb begin
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!valid_q[i]) free_idx = IDX_W'(i);
        end
    end

    assign probe_hit = |m_probe;
    assign full      = &valid_q;
    assign do_alloc  = ins_en && !(|m_ins) && !full;
    assign snoop_hit = snoop_en && ((|m_snp) || (ins_en && (ins_addr == snoop_addr)));

    // Valid bits: set on new fill, cleared in bulk.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_all) valid_q <= '0;
        else if (do_alloc)       valid_q[free_idx] <= 1'b1;
    end

    // Tracked address store.
    always_ff @(posedge clk) begin
        if (do_alloc) addr_q[free_idx] <= ins_addr;
    end

    // R4: a fill of an untracked address adds exactly one entry.
    assert_fill_tracks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_en && !(|m_ins) && !full && !clear_all)
            |=> ($countones(valid_q) == $past($countones(valid_q)) + 1));
endmodule

// File: rtl/spec_commit_cache.sv
// Speculative block commit cache: top level.
// Buffers the block's stores privately and tracks its memory reads.
// Drains the buffer onto the shared write bus when granted the commit turn.
// Raises a violation when a foreign committing write hits a tracked read.
// Assumes one outstanding processor request at a time, and that the
// processor does not raise commit_req while it has a request in flight.
module spec_commit_cache #(
    parameter int          ADDR_W     = 16,
    parameter int          DATA_W     = 32,
    parameter int          WB_ENTRIES = 8,
    parameter int          RT_ENTRIES = 8,
    parameter int          ID_W       = 2,
    parameter logic [ID_W-1:0] SELF_ID = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              proc_req_valid,
    input  logic              proc_req_we,
    input  logic [ADDR_W-1:0] proc_req_addr,
    input  logic [DATA_W-1:0] proc_req_wdata,
    output logic              proc_req_ready,
    output logic              proc_rsp_valid,
    output logic [DATA_W-1:0] proc_rsp_rdata,
    output logic              overflow,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_ack,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              bus_wr_valid,
    output logic [ADDR_W-1:0] bus_wr_addr,
    output logic [DATA_W-1:0] bus_wr_data,
    output logic [ID_W-1:0]   bus_wr_id,
    input  logic              bus_ready,
    input  logic              snoop_valid,
    input  logic [ADDR_W-1:0] snoop_addr,
    input  logic [ID_W-1:0]   snoop_id,
    input  logic              commit_req,
    input  logic              commit_grant,
    output logic              commit_done,
    input  logic              abort_req,
    output logic              abort_done,
    output logic              violation
);
    import scc_pkg::*;

    scc_state_e        state_q;
    logic [ADDR_W-1:0] fetch_addr_q;
    logic              rsp_valid_q, viol_q, cdone_q, adone_q;
    logic [DATA_W-1:0] rsp_data_q;

    logic              wb_hit, wb_full, wb_any, wb_store, wb_pop;
    logic [DATA_W-1:0] wb_hit_data;
    logic              rt_probe_hit, rt_full, rt_snoop_hit;
    logic              idle, blocked, accept, fill, finish, clear_all, foreign;

    // Request admission: a store needs a slot, a load miss needs a tracking slot.
    always_comb begin
        idle     = (state_q == ST_IDLE);
        blocked  = proc_req_we ? (!wb_hit && wb_full)
                               : (!wb_hit && !rt_probe_hit && rt_full);
        proc_req_ready = idle && !abort_req && !commit_req && !(proc_req_valid && blocked);
        overflow = idle && proc_req_valid && blocked;
        accept   = proc_req_valid && proc_req_ready;
        wb_store = accept && proc_req_we;
        fill     = (state_q == ST_FETCH) && mem_rd_ack && !abort_req;
        finish   = (state_q == ST_DRAIN) && !wb_any && !abort_req;
        clear_all = abort_req || finish;
        foreign  = snoop_valid && (snoop_id != SELF_ID);
    end

    scc_write_buffer #(
        .DEPTH (WB_ENTRIES),
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_wbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_all (clear_all),
        .probe_addr(proc_req_addr),
        .store_en  (wb_store),
        .store_data(proc_req_wdata),
        .hit       (wb_hit),
        .hit_data  (wb_hit_data),
        .full      (wb_full),
        .pop_en    (wb_pop),
        .any_valid (wb_any),
        .head_addr (bus_wr_addr),
        .head_data (bus_wr_data)
    );

    scc_read_tracker #(
        .DEPTH (RT_ENTRIES),
        .ADDR_W(ADDR_W)
    ) u_rtrk (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_all (clear_all),
        .probe_addr(proc_req_addr),
        .probe_hit (rt_probe_hit),
        .full      (rt_full),
        .ins_en    (fill),
        .ins_addr  (fetch_addr_q),
        .snoop_en  (foreign),
        .snoop_addr(snoop_addr),
        .snoop_hit (rt_snoop_hit)
    );

    // Bus side of the drain; a raised violation freezes it until abort.
    assign bus_wr_valid = (state_q == ST_DRAIN) && wb_any && !viol_q;
    assign wb_pop       = bus_wr_valid && bus_ready;
    assign bus_wr_id    = SELF_ID;
    assign mem_rd_req   = (state_q == ST_FETCH);
    assign mem_rd_addr  = fetch_addr_q;

    // Control sequencing between idle, memory fetch and commit drain.
    always_ff @(posedge clk) begin
        if (!rst_n || abort_req) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (commit_req && commit_grant && !viol_q)  state_q <= ST_DRAIN;
                    else if (accept && !proc_req_we && !wb_hit) state_q <= ST_FETCH;
                end
                ST_FETCH: if (mem_rd_ack) state_q <= ST_IDLE;
                ST_DRAIN: if (!wb_any)    state_q <= ST_IDLE;
                default:                  state_q <= ST_IDLE;
            endcase
        end
    end

    // Latch the address of a load that missed the write buffer.
    always_ff @(posedge clk) begin
        if (accept && !proc_req_we && !wb_hit) fetch_addr_q <= proc_req_addr;
    end

    // Load response: buffered data on hit, memory data on fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_data_q  <= '0;
        end else begin
            rsp_valid_q <= (accept && !proc_req_we && wb_hit) || fill;
            rsp_data_q  <= fill ? mem_rd_data : wb_hit_data;
        end
    end

    // Sticky dependency violation, cleared only by abort.
    always_ff @(posedge clk) begin
        if (!rst_n || abort_req) viol_q <= 1'b0;
        else if (rt_snoop_hit)   viol_q <= 1'b1;
    end

    // Completion pulses for commit and abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cdone_q <= 1'b0;
            adone_q <= 1'b0;
        end else begin
            cdone_q <= finish;
            adone_q <= abort_req;
        end
    end

    assign proc_rsp_valid = rsp_valid_q;
    assign proc_rsp_rdata = rsp_data_q;
    assign violation      = viol_q;
    assign commit_done    = cdone_q;
    assign abort_done     = adone_q;

    // R7: a stalled bus write keeps its word until taken (or a violation freezes it).
    assert_drain_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_valid && !bus_ready && !abort_req)
            |=> (violation || (bus_wr_valid && $stable(bus_wr_addr) && $stable(bus_wr_data))));

    // R9: abort completes in one cycle with no violation and no bus write.
    assert_abort_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req |=> (abort_done && !violation && !bus_wr_valid));

    // R5: a violation holds until an abort.
    assert_violation_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (violation && !abort_req) |=> violation);

    // R4: an acknowledged fill responds on the next cycle.
    assert_fill_responds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && mem_rd_ack && !abort_req) |=> proc_rsp_valid);

    // R10: an overflowing request is never accepted.
    assert_no_overflow_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> !proc_req_ready);
endmodule

// File: tb/spec_commit_cache_bench.sv
`timescale 1ns/1ps
// Bench for the speculative commit cache.
// A behavioural model (associative arrays, queues) predicts the buffered
// contents, drain order and violation flag. The violation flag and the
// bus-write rule are compared on every clock.
module spec_commit_cache_bench;
    localparam logic [1:0] ME    = 2'd1;
    localparam logic [1:0] OTHER = 2'd2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        proc_req_valid = 0, proc_req_we = 0;
    logic [15:0] proc_req_addr = 0;
    logic [31:0] proc_req_wdata = 0;
    logic        proc_req_ready, proc_rsp_valid, overflow;
    logic [31:0] proc_rsp_rdata;
    logic        mem_rd_req, mem_rd_ack = 0;
    logic [15:0] mem_rd_addr;
    logic [31:0] mem_rd_data;
    logic        bus_wr_valid, bus_ready = 0;
    logic [15:0] bus_wr_addr;
    logic [31:0] bus_wr_data;
    logic [1:0]  bus_wr_id;
    logic        snoop_valid = 0;
    logic [15:0] snoop_addr = 0;
    logic [1:0]  snoop_id = 0;
    logic        commit_req = 0, commit_grant = 0, commit_done;
    logic        abort_req = 0, abort_done, violation;

    always #4 clk = ~clk;

    function automatic logic [31:0] mem_fn(input logic [15:0] a);
        return {~a, a};
    endfunction
    assign mem_rd_data = mem_fn(mem_rd_addr);

    spec_commit_cache #(.SELF_ID(ME)) u_spec_commit_cache (
        .clk(clk), .rst_n(rst_n),
        .proc_req_valid(proc_req_valid), .proc_req_we(proc_req_we),
        .proc_req_addr(proc_req_addr), .proc_req_wdata(proc_req_wdata),
        .proc_req_ready(proc_req_ready), .proc_rsp_valid(proc_rsp_valid),
        .proc_rsp_rdata(proc_rsp_rdata), .overflow(overflow),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_ack(mem_rd_ack), .mem_rd_data(mem_rd_data),
        .bus_wr_valid(bus_wr_valid), .bus_wr_addr(bus_wr_addr),
        .bus_wr_data(bus_wr_data), .bus_wr_id(bus_wr_id), .bus_ready(bus_ready),
        .snoop_valid(snoop_valid), .snoop_addr(snoop_addr), .snoop_id(snoop_id),
        .commit_req(commit_req), .commit_grant(commit_grant), .commit_done(commit_done),
        .abort_req(abort_req), .abort_done(abort_done), .violation(violation)
    );

    int errs = 0, checks = 0, cyc = 0;
    bit live = 0;

    // Model state
    logic [31:0] m_wb [logic [15:0]];
    logic [15:0] m_order [$];
    bit          m_trk [logic [15:0]];
    bit          m_viol = 0, m_drain = 0;
    logic        s_rd_req = 0;
    logic [15:0] s_rd_addr = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Model update at the edge: fills, snoop hits, aborts.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_viol = 0;
            m_trk.delete();
        end else if (abort_req) begin
            m_viol = 0;
            m_trk.delete();
        end else begin
            if (snoop_valid && snoop_id != ME &&
                (m_trk.exists(snoop_addr) ||
                 (s_rd_req && mem_rd_ack && s_rd_addr == snoop_addr)))
                m_viol = 1;
            if (s_rd_req && mem_rd_ack) m_trk[s_rd_addr] = 1;
        end
    end

    // Per-clock comparison away from the edge.
    always @(negedge clk) begin
        s_rd_req  = mem_rd_req;
        s_rd_addr = mem_rd_addr;
        if (live) begin
            chk(violation == m_viol, "R5/R6 violation per clock", {31'd0, violation}, {31'd0, m_viol});
            chk(!(bus_wr_valid && !m_drain), "R2 bus write outside commit", {31'd0, bus_wr_valid}, 32'd0);
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errs++; checks++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    task automatic do_store(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        proc_req_valid = 1; proc_req_we = 1; proc_req_addr = a; proc_req_wdata = d;
        #1 chk(proc_req_ready, "R2 store accepted", {31'd0, proc_req_ready}, 32'd1);
        @(posedge clk);
        @(negedge clk);
        proc_req_valid = 0; proc_req_we = 0;
        if (!m_wb.exists(a)) m_order.push_back(a);
        m_wb[a] = d;
    endtask

    task automatic do_load(input logic [15:0] a, input int lat, input bit snp);
        @(negedge clk);
        proc_req_valid = 1; proc_req_we = 0; proc_req_addr = a;
        #1 chk(proc_req_ready, "R3/R4 load accepted", {31'd0, proc_req_ready}, 32'd1);
        @(posedge clk);
        @(negedge clk);
        proc_req_valid = 0;
        if (m_wb.exists(a)) begin
            chk(proc_rsp_valid && proc_rsp_rdata == m_wb[a], "R3 buffered data", proc_rsp_rdata, m_wb[a]);
            chk(!mem_rd_req, "R3 no memory read", {31'd0, mem_rd_req}, 32'd0);
        end else begin
            chk(mem_rd_req && mem_rd_addr == a, "R4 fetch address", {15'd0, mem_rd_req, mem_rd_addr}, {16'd1, a});
            chk(!proc_rsp_valid, "R4 no early response", {31'd0, proc_rsp_valid}, 32'd0);
            for (int i = 0; i < lat; i++) begin
                @(negedge clk);
                chk(mem_rd_req, "R4 read held", {31'd0, mem_rd_req}, 32'd1);
            end
            mem_rd_ack = 1;
            if (snp) begin snoop_valid = 1; snoop_addr = a; snoop_id = OTHER; end
            @(posedge clk);
            @(negedge clk);
            mem_rd_ack = 0; snoop_valid = 0;
            chk(proc_rsp_valid && proc_rsp_rdata == mem_fn(a), "R4 fill data", proc_rsp_rdata, mem_fn(a));
            chk(!mem_rd_req, "R4 read ends", {31'd0, mem_rd_req}, 32'd0);
        end
    endtask

    task automatic do_snoop(input logic [15:0] a, input logic [1:0] id, input bit expv, input string tag);
        @(negedge clk);
        snoop_valid = 1; snoop_addr = a; snoop_id = id;
        @(posedge clk);
        @(negedge clk);
        snoop_valid = 0;
        chk(violation == expv, tag, {31'd0, violation}, {31'd0, expv});
    endtask

    task automatic do_abort(input logic [15:0] a, input bit snp);
        @(negedge clk);
        abort_req = 1;
        if (snp) begin snoop_valid = 1; snoop_addr = a; snoop_id = OTHER; end
        @(posedge clk);
        @(negedge clk);
        abort_req = 0; snoop_valid = 0;
        chk(abort_done, "R9 abort_done pulse", {31'd0, abort_done}, 32'd1);
        chk(!violation, "R9 violation cleared", {31'd0, violation}, 32'd0);
        m_wb.delete(); m_order.delete();
        @(negedge clk);
        chk(!abort_done, "R9 abort_done one cycle", {31'd0, abort_done}, 32'd0);
    endtask

    task automatic do_commit(input logic [3:0] pat);
        int n = 0, exp_n;
        bit done = 0;
        exp_n = m_order.size();
        @(negedge clk);
        commit_req = 1; commit_grant = 1; m_drain = 1; bus_ready = pat[0];
        @(posedge clk);
        for (int i = 0; i < 64 && !done; i++) begin
            @(negedge clk);
            commit_req = 0; commit_grant = 0;
            if (commit_done) done = 1;
            else begin
                bus_ready = pat[i % 4];
                if (bus_wr_valid) begin
                    if (m_order.size() == 0) chk(0, "R7 unexpected bus write", {16'd0, bus_wr_addr}, 32'd0);
                    else begin
                        chk(bus_wr_addr == m_order[0] && bus_wr_data == m_wb[m_order[0]],
                            "R7 drain order and data", {16'd0, bus_wr_addr}, {16'd0, m_order[0]});
                        chk(bus_wr_id == ME, "R7 write tag", {30'd0, bus_wr_id}, {30'd0, ME});
                        if (bus_ready) begin
                            m_wb.delete(m_order[0]);
                            void'(m_order.pop_front());
                            n++;
                        end
                    end
                end
            end
        end
        bus_ready = 0;
        chk(done, "R8 commit_done seen", {31'd0, done}, 32'd1);
        chk(n == exp_n, "R8 write count", n, exp_n);
        m_drain = 0; m_trk.delete(); m_wb.delete(); m_order.delete();
        @(negedge clk);
        chk(!commit_done, "R8 commit_done one cycle", {31'd0, commit_done}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        live = 1;
        // R1 reset state
        chk(proc_req_ready && !proc_rsp_valid && !mem_rd_req && !bus_wr_valid && !violation &&
            !overflow && !commit_done && !abort_done, "R1 reset outputs",
            {24'd0, proc_req_ready, proc_rsp_valid, mem_rd_req, bus_wr_valid, violation,
             overflow, commit_done, abort_done}, 32'h80);

        // R2/R3/R11: buffered stores, hits, overwrite
        do_store(16'h0011, 32'hA0000001);
        do_store(16'h0012, 32'hA0000002);
        do_store(16'h0013, 32'hA0000003);
        do_load(16'h0012, 0, 0);
        do_store(16'h0012, 32'hB0000002);          // R11 overwrite in place
        do_load(16'h0012, 0, 0);
        // R4 miss with latency
        do_load(16'h0044, 2, 0);
        // R7: commit requested without grant -> no drain
        @(negedge clk);
        commit_req = 1; commit_grant = 0;
        repeat (3) begin
            @(negedge clk);
            chk(!bus_wr_valid, "R7 no drain without grant", {31'd0, bus_wr_valid}, 32'd0);
        end
        commit_req = 0;
        // R7/R8 drain with bus stalls
        do_commit(4'b0101);
        // R8: stores now empty, former buffered address reads memory
        do_load(16'h0011, 0, 0);
        do_commit(4'b1111);

        // R5/R6 snoop behaviour
        do_load(16'h0010, 1, 0);
        do_snoop(16'h0010, ME, 0, "R6 own-ID snoop ignored");
        do_snoop(16'h0020, OTHER, 0, "R6 untracked snoop ignored");
        do_store(16'h0050, 32'hC0000050);
        do_snoop(16'h0010, OTHER, 1, "R5 foreign snoop hit");
        // R7: no drain while violation
        @(negedge clk);
        commit_req = 1; commit_grant = 1;
        @(negedge clk);
        commit_req = 0; commit_grant = 0;
        repeat (3) begin
            @(negedge clk);
            chk(!bus_wr_valid && !commit_done, "R7 no drain under violation",
                {30'd0, bus_wr_valid, commit_done}, 32'd0);
        end
        do_abort(16'h0000, 0);
        // R9: discarded store is gone, load goes to memory
        do_load(16'h0050, 0, 0);

        // R5: fill and snoop same cycle
        do_load(16'h0060, 0, 1);
        chk(violation, "R5 fill-cycle snoop", {31'd0, violation}, 32'd1);
        do_abort(16'h0000, 0);
        // R9: abort beats a simultaneous snoop hit
        do_load(16'h0070, 0, 0);
        do_abort(16'h0070, 1);

        // R10/R11: write buffer full
        for (int i = 0; i < 8; i++) do_store(16'h0100 + 16'(i), 32'hD0000000 + i);
        @(negedge clk);
        proc_req_valid = 1; proc_req_we = 1; proc_req_addr = 16'h0200; proc_req_wdata = 32'hEEEE0200;
        repeat (3) begin
            #1 chk(overflow && !proc_req_ready, "R10 full buffer stalls",
                   {30'd0, overflow, proc_req_ready}, 32'h2);
            @(negedge clk);
        end
        proc_req_addr = 16'h0103; proc_req_wdata = 32'hF0000103;
        #1 chk(!overflow && proc_req_ready, "R11 overwrite while full",
               {30'd0, overflow, proc_req_ready}, 32'h1);
        @(posedge clk);
        @(negedge clk);
        proc_req_valid = 0; proc_req_we = 0;
        m_wb[16'h0103] = 32'hF0000103;
        do_commit(4'b0011);
        do_store(16'h0200, 32'hEEEE0200);            // R10 freed by commit
        do_load(16'h0200, 0, 0);
        do_abort(16'h0000, 0);

        // R12: tracking set full
        for (int i = 0; i < 8; i++) do_load(16'h0300 + 16'(i), 0, 0);
        @(negedge clk);
        proc_req_valid = 1; proc_req_we = 0; proc_req_addr = 16'h0400;
        #1 chk(overflow && !proc_req_ready, "R12 full tracker stalls",
               {30'd0, overflow, proc_req_ready}, 32'h2);
        proc_req_addr = 16'h0302;
        #1 chk(!overflow && proc_req_ready, "R12 tracked address proceeds",
               {30'd0, overflow, proc_req_ready}, 32'h1);
        proc_req_valid = 0;
        do_load(16'h0302, 0, 0);
        do_abort(16'h0000, 0);

        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule